// File: doc/BRIEF.md
# Subranging Gated Frequency Counter

This block measures the rate of an asynchronous pulse train by counting its rising edges while a gate window is open. The window is the high half of a slow reference clock, and both the pulse input and the reference are brought into a fast sampling clock domain through two-flop synchronizers. When the reference falls, the block closes the window. It latches the fine count together with the present subrange code from the range controller, strobes the result out, and clears the counter for the next window.

The count is compared against a band whose upper limit is about ten times its lower limit. A count above the band raises an over-range flag and a count below it raises an under-range flag. An outer control loop uses these flags to step the analog front end into a neighbouring range. It does not rely on the counter wrapping. The limits are slightly wider than the nominal band, so adjacent ranges overlap and the loop does not hunt. A miscount of one edge at a window boundary is inherent to the method and accepted.

Top module: `subrange_freq_counter`

## Requirements
- R1: After reset, `result` is 0, and `valid`, `over_flag` and `under_flag` are low.
- R2: While the synchronized reference is high, each rising edge of `pulse_in` adds one to the fine count. Rising edges that occur while the reference is low are not counted.
- R3: One cycle after the synchronized reference falls, `valid` is high for exactly one cycle. The next window's count starts again from zero.
- R4: The result word carries the fine count in bits 12 to 0 and the value of `range_code` at window close in bits 15 to 13. Between strobes the word holds its value.
- R5: `over_flag` is set with the strobe when the count is greater than HI_LIM (default 5100). A count equal to HI_LIM does not set it.
- R6: `under_flag` is set with the strobe when the count is less than LO_LIM (default 480). A count equal to LO_LIM does not set it.
- R7: The fine count saturates at 8191 instead of wrapping, so more than 8191 edges in a window read as 8191 and set the over-range flag.
- R8: At most one flag is set at a time. Both flags clear when a window's count lies inside the band, and they change only at a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_clk | input | 1 | Slow reference; its high phase is the gate window |
| pulse_in | input | 1 | Asynchronous pulse train from the oscillator |
| range_code | input | 3 | Current subrange code from the range controller |
| result | output | 16 | Subrange code above the 13-bit fine count |
| valid | output | 1 | One-cycle strobe for a new result |
| over_flag | output | 1 | Count lay above the band |
| under_flag | output | 1 | Count lay below the band |

## Verification
The windows use edge counts on both sides of each limit: 0, 479, 480, 5100, 5101 and a mid-band value. These show whether each threshold is strict and which flag owns each boundary. Counts of exactly 8191 and well beyond it separate saturation from wrapping. Several windows add bursts of edges while the reference is low, to show that the gate excludes them. The pulse duty cycle varies and the range code changes from window to window, which shows that pulse shape is irrelevant and that the code is captured per window. After each window the held outputs are compared again before the next stimulus.

// File: rtl/subrange_freq_counter.sv
module subrange_freq_counter #(
  parameter int CNT_W  = 13,
  parameter int CODE_W = 3,
  parameter int HI_LIM = 5100,
  parameter int LO_LIM = 480,
  parameter int SYNC_N = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ref_clk,
  input  logic                    pulse_in,
  input  logic [CODE_W-1:0]       range_code,
  output logic [CNT_W+CODE_W-1:0] result,
  output logic                    valid,
  output logic                    over_flag,
  output logic                    under_flag
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] HI_C    = CNT_W'(HI_LIM);
  localparam logic [CNT_W-1:0] LO_C    = CNT_W'(LO_LIM);

  logic [SYNC_N-1:0] ref_sh, pin_sh;
  logic              ref_d, pin_d;
  logic [CNT_W-1:0]  count;

  wire gate     = ref_sh[SYNC_N-1];
  wire pin_s    = pin_sh[SYNC_N-1];
  wire close    = ref_d & ~gate;
  wire edge_hit = gate & pin_s & ~pin_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_sh <= '0;
      pin_sh <= '0;
      ref_d  <= 1'b0;
      pin_d  <= 1'b0;
    end else begin
      ref_sh <= {ref_sh[SYNC_N-2:0], ref_clk};
      pin_sh <= {pin_sh[SYNC_N-2:0], pulse_in};
      ref_d  <= gate;
      pin_d  <= pin_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (close)
      count <= '0;
    else if (edge_hit && count != CNT_MAX)
      count <= count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result     <= '0;
      valid      <= 1'b0;
      over_flag  <= 1'b0;
      under_flag <= 1'b0;
    end else begin
      valid <= close;
      if (close) begin
        result     <= {range_code, count};
        over_flag  <= count > HI_C;
        under_flag <= count < LO_C;
      end
    end
  end
endmodule

// File: rtl/subrange_freq_counter_chk.sv
module subrange_freq_counter_chk #(
  parameter int CNT_W  = 13,
  parameter int CODE_W = 3,
  parameter int HI_LIM = 5100,
  parameter int LO_LIM = 480
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [CNT_W+CODE_W-1:0] result,
  input logic                    valid,
  input logic                    over_flag,
  input logic                    under_flag
);
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  a_r4_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> $stable(result));

  a_r5_over_matches: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (over_flag == (int'(result[CNT_W-1:0]) > HI_LIM)));

  a_r6_under_matches: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (under_flag == (int'(result[CNT_W-1:0]) < LO_LIM)));

  a_r8_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !(over_flag && under_flag));

  a_r8_flags_held: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> ($stable(over_flag) && $stable(under_flag)));
endmodule

bind subrange_freq_counter subrange_freq_counter_chk #(
  .CNT_W(CNT_W), .CODE_W(CODE_W), .HI_LIM(HI_LIM), .LO_LIM(LO_LIM)
) u_chk (
  .clk(clk), .rst_n(rst_n), .result(result), .valid(valid),
  .over_flag(over_flag), .under_flag(under_flag)
);

// File: tb/tb_subrange_freq_counter.sv
module tb_subrange_freq_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_clk = 1'b0;
  logic        pulse_in = 1'b0;
  logic [2:0]  range_code = 3'd0;
  logic [15:0] result;
  logic        valid, over_flag, under_flag;

  int total = 0;
  int bad = 0;
  logic [17:0] expq[$];
  logic [17:0] last_exp = '0;

  always #2 clk = ~clk;

  subrange_freq_counter dut (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .pulse_in(pulse_in),
    .range_code(range_code), .result(result), .valid(valid),
    .over_flag(over_flag), .under_flag(under_flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic pulses(input int n, input int hi_w, input int lo_w);
    for (int i = 0; i < n; i++) begin
      pulse_in = 1'b1;
      repeat (hi_w) @(negedge clk);
      pulse_in = 1'b0;
      repeat (lo_w) @(negedge clk);
    end
  endtask

  task automatic window(input int n, input int hi_w, input int lo_w,
                        input int pre, input logic [2:0] code);
    int sat;
    logic [17:0] e;
    sat = (n > 8191) ? 8191 : n;
    e = {(sat > 5100), (sat < 480), code, 13'(sat)};
    expq.push_back(e);
    @(negedge clk);
    range_code = code;
    pulses(pre, 1, 1);
    repeat (2) @(negedge clk);
    ref_clk = 1'b1;
    repeat (4) @(negedge clk);
    pulses(n, hi_w, lo_w);
    repeat (4) @(negedge clk);
    ref_clk = 1'b0;
    pulses(pre, 2, 1);
    repeat (8) @(negedge clk);
    range_code = ~code;
    @(negedge clk);
    // R8 R4: outputs held after the strobe
    check(result == e[15:0] && over_flag == e[17] && under_flag == e[16] && !valid,
          "R8 held", {valid, over_flag, under_flag, result}, {1'b0, e});
    last_exp = e;
  endtask

  always @(negedge clk) begin
    if (rst_n && valid) begin
      logic [17:0] e;
      if (expq.size() == 0) begin
        check(1'b0, "R3 unexpected strobe", result, 0);
      end else begin
        e = expq.pop_front();
        // R2 R4 R7: count and code field
        check(result == e[15:0], "R2/R4/R7 word", result, e[15:0]);
        // R5 R6 R8: flags
        check(over_flag == e[17], "R5 over_flag", over_flag, e[17]);
        check(under_flag == e[16], "R6 under_flag", under_flag, e[16]);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(result == 16'd0 && !valid && !over_flag && !under_flag, "R1 reset",
          {valid, over_flag, under_flag, result}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(result == 16'd0 && !valid && !over_flag && !under_flag, "R1 after release",
          {valid, over_flag, under_flag, result}, 0);

    window(0,    1, 1, 5,  3'd2);  // R6 empty window, R2 gated edges ignored
    window(3000, 1, 2, 0,  3'd1);  // R8 in band clears flags
    window(479,  2, 1, 20, 3'd0);  // R6 just below
    window(480,  1, 1, 0,  3'd5);  // R6 boundary in band
    window(5100, 1, 1, 0,  3'd4);  // R5 boundary in band
    window(5101, 1, 1, 0,  3'd3);  // R5 just above
    window(1234, 3, 2, 30, 3'd6);  // R3 counter restarts from zero
    window(8191, 1, 1, 0,  3'd7);  // R7 exactly full scale
    window(9000, 1, 1, 0,  3'd2);  // R7 saturates rather than wraps
    window(700,  1, 1, 0,  3'd0);  // R8 back in band

    repeat (10) @(negedge clk);
    // R3: every window produced exactly one strobe
    check(expq.size() == 0, "R3 strobe count", expq.size(), 0);
    finish_up();
  end
endmodule